// File: doc/BRIEF.md
# MSI Interrupt Message Generator

This block converts three internal outbound interrupt sources (a post-queue interrupt, a doorbell interrupt and a message interrupt) into either message-signaled interrupt writes or an active-low wired interrupt level. Configuration software programs the MSI capability state through a small word-addressed register port: a control word, the lower and upper halves of the message address, and the message data word. When the enable bit is clear, the wired output follows the unmasked sources. When it is set, the wired output stays high and each source edge becomes a memory write request on a request/acknowledge master port.

The granted message count selects one of two mappings. With one vector, every source shares vector 0 and the programmed data word is sent unchanged. With two vectors, the post-queue source owns vector 0 and the doorbell and message sources share vector 1. Bit 0 of the data then carries the vector index. A non-zero upper address half marks the write as a dual-address-cycle transfer. Only one write is outstanding at a time. Edges that arrive while a write is in flight are kept as pending per vector.

Top module: `msi_irq_gen`

## Requirements
- R1: Register port, word select `cfg_addr` (0 control, 1 address low, 2 address high, 3 data). The read data is registered, so it is valid one cycle after the select. The control word reads bit 0 = enable (writable), bits 3:1 = 3'b001 (two messages capable, read-only), bits 6:4 = granted count field (writable, read back as written), bit 7 = 1 (64-bit capable, read-only), and all other bits 0. Address low bits 1:0 read as 0. Address high and data read back as written.
- R2: With enable clear, `irq_n` goes low one cycle after any unmasked source is high and returns high one cycle after none is. No write request is raised.
- R3: With enable set, `irq_n` is held high.
- R4: With granted count field 1, source 0 (post queue, `irq_src[0]`) writes data with bit 0 = 0. Sources 1 and 2 (doorbell, message) write data with bit 0 = 1. Bits 31:1 are the programmed data.
- R5: With granted count field 0, every source writes the programmed data word unchanged, including bit 0.
- R6: Granted count field values 2 to 7 behave exactly like 1.
- R7: `req_addr` is {address high, address low}, and `req_dac` is 1 exactly when address high is non-zero.
- R8: An unmasked source rising edge raises `req_valid` two cycles after the source is driven. A source held high produces no further write after the acknowledge.
- R9: A rising edge on a source whose vector already has a write in flight produces one more write. Its request appears the cycle after the acknowledged cycle.
- R10: When both vectors are pending, vector 0 is issued first. A request holds its address, data and flag stable until `req_ack`.
- R11: A source whose `irq_mask` bit is 1 affects neither `irq_n` nor the write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register word select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for `cfg_addr` |
| irq_src | input | 3 | Sources: 0 post queue, 1 doorbell, 2 message |
| irq_mask | input | 3 | Per-source mask, 1 = ignored |
| irq_n | output | 1 | Active-low wired interrupt |
| req_valid | output | 1 | Write request outstanding |
| req_ack | input | 1 | Write request accepted |
| req_addr | output | 64 | Write address |
| req_dac | output | 1 | Dual-address-cycle write |
| req_data | output | 32 | Write payload |

## Verification
The embedded properties watch four things on every cycle: the wired output stays quiet while messaging is enabled, no write starts while it is disabled, a request stays stable until it is acknowledged, and the dual-cycle flag agrees with the upper half of the address. The vector mapping under each granted count, the data bit substitution, vector priority, re-arming on an edge during a transfer, masking and register readback all need sequences of stimulus. The bench sweeps every granted count value against every source and both address ranges to show these.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned NUM_SRC = 3;
  localparam int unsigned NUM_VEC = 2;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ALO  = 2'd1,
    SEL_AHI  = 2'd2,
    SEL_DATA = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_wr,
  input  logic [1:0]   cfg_addr,
  input  logic [W-1:0] cfg_wdata,
  output logic [W-1:0] cfg_rdata,
  output logic         msi_en,
  output logic         two_msg,
  output logic [W-1:0] addr_lo,
  output logic [W-1:0] addr_hi,
  output logic [W-1:0] msg_data
);
  logic [2:0]   mme_q;
  logic [W-1:0] ctrl_view;

  always_ff @(posedge clk) begin
    if (rst) begin
      msi_en   <= 1'b0;
      mme_q    <= '0;
      addr_lo  <= '0;
      addr_hi  <= '0;
      msg_data <= '0;
    end else if (cfg_wr) begin
      unique case (cfg_sel_e'(cfg_addr))
        SEL_CTRL: begin
          msi_en <= cfg_wdata[0];
          mme_q  <= cfg_wdata[6:4];
        end
        SEL_ALO:  addr_lo  <= {cfg_wdata[W-1:2], 2'b00};
        SEL_AHI:  addr_hi  <= cfg_wdata;
        SEL_DATA: msg_data <= cfg_wdata;
      endcase
    end
  end

  // any grant above one message is served as two vectors
  assign two_msg   = (mme_q != 3'd0);
  assign ctrl_view = {{(W-8){1'b0}}, 1'b1, mme_q, 3'b001, msi_en};

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else begin
      unique case (cfg_sel_e'(cfg_addr))
        SEL_CTRL: cfg_rdata <= ctrl_view;
        SEL_ALO:  cfg_rdata <= addr_lo;
        SEL_AHI:  cfg_rdata <= addr_hi;
        SEL_DATA: cfg_rdata <= msg_data;
      endcase
    end
  end
endmodule

// File: rtl/msi_vec_track.sv
module msi_vec_track
  import msi_pkg::*;
#(
  parameter int unsigned NSRC = NUM_SRC,
  parameter int unsigned NVEC = NUM_VEC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] mask,
  input  logic            msi_en,
  input  logic            two_msg,
  input  logic            issue,
  input  logic            issue_idx,
  output logic [NVEC-1:0] pend
);
  logic [NSRC-1:0] src_q;
  logic [NSRC-1:0] rise_m;
  logic [NVEC-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= src;
  end

  assign rise_m = src & ~src_q & ~mask;
  assign hit[0] = two_msg ? rise_m[0] : |rise_m;
  assign hit[1] = two_msg & (|rise_m[NSRC-1:1]);

  for (genvar v = 0; v < NVEC; v++) begin : g_vec
    logic taken;
    assign taken = issue && (issue_idx == 1'(v));
    always_ff @(posedge clk) begin
      if (rst || !msi_en) pend[v] <= 1'b0;
      else                pend[v] <= (pend[v] & ~taken) | hit[v];
    end
  end
endmodule

// File: rtl/msi_write_arb.sv
module msi_write_arb
  import msi_pkg::*;
#(
  parameter int unsigned W    = WORD_W,
  parameter int unsigned NVEC = NUM_VEC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            msi_en,
  input  logic            two_msg,
  input  logic [NVEC-1:0] pend,
  input  logic [W-1:0]    addr_lo,
  input  logic [W-1:0]    addr_hi,
  input  logic [W-1:0]    msg_data,
  input  logic            req_ack,
  output logic            issue,
  output logic            issue_idx,
  output logic            req_valid,
  output logic [2*W-1:0]  req_addr,
  output logic            req_dac,
  output logic [W-1:0]    req_data
);
  assign issue     = msi_en && !req_valid && (|pend);
  assign issue_idx = pend[0] ? 1'b0 : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_dac   <= 1'b0;
      req_data  <= '0;
    end else if (issue) begin
      req_valid <= 1'b1;
      req_addr  <= {addr_hi, addr_lo};
      req_dac   <= (addr_hi != '0);
      req_data  <= two_msg ? {msg_data[W-1:1], issue_idx} : msg_data;
    end else if (req_valid && req_ack) begin
      req_valid <= 1'b0;
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ack) |=> (req_valid && $stable(req_addr) &&
                                 $stable(req_data) && $stable(req_dac)));

  // R7
  dac_flag_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_dac == (req_addr[2*W-1:W] != '0)));
endmodule

// File: rtl/msi_irq_gen.sv
module msi_irq_gen
  import msi_pkg::*;
#(
  parameter int unsigned W    = WORD_W,
  parameter int unsigned NSRC = NUM_SRC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_wr,
  input  logic [1:0]      cfg_addr,
  input  logic [W-1:0]    cfg_wdata,
  output logic [W-1:0]    cfg_rdata,
  input  logic [NSRC-1:0] irq_src,
  input  logic [NSRC-1:0] irq_mask,
  output logic            irq_n,
  output logic            req_valid,
  input  logic            req_ack,
  output logic [2*W-1:0]  req_addr,
  output logic            req_dac,
  output logic [W-1:0]    req_data
);
  logic                msi_en, two_msg, issue, issue_idx;
  logic [W-1:0]        addr_lo, addr_hi, msg_data;
  logic [NUM_VEC-1:0]  pend;

  msi_cap_regs #(.W(W)) u_regs (
    .clk, .rst, .cfg_wr, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .msi_en, .two_msg, .addr_lo, .addr_hi, .msg_data
  );

  msi_vec_track #(.NSRC(NSRC), .NVEC(NUM_VEC)) u_track (
    .clk, .rst, .src(irq_src), .mask(irq_mask), .msi_en, .two_msg,
    .issue, .issue_idx, .pend
  );

  msi_write_arb #(.W(W), .NVEC(NUM_VEC)) u_arb (
    .clk, .rst, .msi_en, .two_msg, .pend, .addr_lo, .addr_hi, .msg_data,
    .req_ack, .issue, .issue_idx, .req_valid, .req_addr, .req_dac, .req_data
  );

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~(!msi_en && (|(irq_src & ~irq_mask)));
  end

  // R3
  pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    msi_en |=> irq_n);

  // R2
  no_write_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!msi_en && !req_valid) |=> !req_valid);
endmodule

// File: tb/msi_irq_gen_tb.sv
module msi_irq_gen_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic [2:0]  irq_src, irq_mask;
  logic        irq_n, req_valid, req_ack, req_dac;
  logic [63:0] req_addr;
  logic [31:0] req_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  msi_irq_gen u_dut (
    .clk, .rst, .cfg_wr, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .irq_src, .irq_mask, .irq_n, .req_valid, .req_ack,
    .req_addr, .req_dac, .req_data
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a;
    @(posedge clk); #1 d = cfg_rdata;
  endtask

  task automatic raise(input int s);
    @(negedge clk); irq_src[s] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
  endtask

  task automatic ack_now;
    @(negedge clk); req_ack = 1;
    @(posedge clk); #1 chk("R8 valid drops on ack", 64'(req_valid), 64'd0);
    @(negedge clk); req_ack = 0;
  endtask

  task automatic quiet(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 chk(tag, 64'(req_valid), 64'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, dval, lo, hi;
    rst = 1; cfg_wr = 0; cfg_addr = 0; cfg_wdata = 0;
    irq_src = 0; irq_mask = 0; req_ack = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1 chk("reset irq_n", 64'(irq_n), 64'd1);
    chk("reset req_valid", 64'(req_valid), 64'd0);

    // R1 readback
    rd(2'd0, r); chk("R1 ctrl reset", 64'(r), 64'h82);
    wr(2'd0, 32'hFFFF_FF7F);
    rd(2'd0, r); chk("R1 ctrl fields", 64'(r), 64'hF3);
    wr(2'd1, 32'h1234_5677);
    rd(2'd1, r); chk("R1 addr low aligned", 64'(r), 64'h1234_5674);
    wr(2'd2, 32'hCAFE_0001);
    rd(2'd2, r); chk("R1 addr high", 64'(r), 64'hCAFE_0001);
    wr(2'd3, 32'hDEAD_BEEF);
    rd(2'd3, r); chk("R1 data", 64'(r), 64'hDEAD_BEEF);
    wr(2'd0, 32'h0);

    // R2 wired pin with messaging off, each source
    for (int s = 0; s < 3; s++) begin
      @(negedge clk); irq_src[s] = 1;
      @(posedge clk); #1 chk("R2 pin low", 64'(irq_n), 64'd0);
      chk("R2 no write", 64'(req_valid), 64'd0);
      @(negedge clk); irq_src[s] = 0;
      @(posedge clk); #1 chk("R2 pin high", 64'(irq_n), 64'd1);
    end
    // R11 masked source, messaging off
    irq_mask = 3'b010;
    @(negedge clk); irq_src[1] = 1;
    @(posedge clk); #1 chk("R11 masked pin", 64'(irq_n), 64'd1);
    @(negedge clk); irq_src[1] = 0;

    // R4 R5 R6 R7 sweep: every grant value, both address ranges, every source
    for (int m = 0; m < 8; m++) begin
      for (int h = 0; h < 2; h++) begin
        irq_mask = 0;
        dval = 32'h1234_5670 | 32'(m);
        lo   = 32'hFEE0_0000 + 32'(m * 16);
        hi   = (h != 0) ? 32'h0000_0010 + 32'(m) : 32'h0;
        wr(2'd1, lo + 32'd3); wr(2'd2, hi); wr(2'd3, dval);
        wr(2'd0, 32'(m << 4) | 32'h1);
        for (int s = 0; s < 3; s++) begin
          logic [31:0] ed;
          ed = (m == 0) ? dval : {dval[31:1], (s != 0)};
          raise(s);
          chk(m == 0 ? "R5 req_valid" : "R4 R6 req_valid", 64'(req_valid), 64'd1);
          chk(m == 0 ? "R5 data" : (m == 1 ? "R4 data" : "R6 data"), 64'(req_data), 64'(ed));
          chk("R7 addr", req_addr, {hi, lo});
          chk("R7 dac", 64'(req_dac), 64'(h != 0));
          chk("R3 pin quiet", 64'(irq_n), 64'd1);
          ack_now();
          quiet("R8 level held no repeat", 3);
          @(negedge clk); irq_src[s] = 0;
        end
      end
    end

    // R9 edge during transfer, two-message mode
    wr(2'd2, 32'h0); wr(2'd3, 32'h0000_00A1); wr(2'd0, 32'h11);
    raise(0);
    chk("R9 first req", 64'(req_valid), 64'd1);
    @(negedge clk); irq_src[0] = 0;
    @(negedge clk); irq_src[0] = 1;
    @(negedge clk); req_ack = 1;
    @(posedge clk); #1 chk("R9 gap after ack", 64'(req_valid), 64'd0);
    @(negedge clk); req_ack = 0;
    @(posedge clk); #1 chk("R9 second req", 64'(req_valid), 64'd1);
    chk("R9 second data", 64'(req_data), 64'h0000_00A0);
    ack_now();
    quiet("R9 only one extra", 3);
    @(negedge clk); irq_src[0] = 0;

    // R10 both vectors pending, vector 0 first, held stable
    @(negedge clk); irq_src = 3'b101;
    @(posedge clk); @(posedge clk); #1;
    chk("R10 vector0 first", 64'(req_data), 64'h0000_00A0);
    repeat (3) @(posedge clk);
    #1 chk("R10 held valid", 64'(req_valid), 64'd1);
    chk("R10 held data", 64'(req_data), 64'h0000_00A0);
    ack_now();
    @(posedge clk); #1 chk("R10 vector1 next", 64'(req_data), 64'h0000_00A1);
    ack_now();
    quiet("R10 no third", 3);
    @(negedge clk); irq_src = 0;

    // R11 masked source with messaging on
    irq_mask = 3'b001;
    raise(0);
    quiet("R11 masked no write", 3);
    @(negedge clk); irq_src = 0; irq_mask = 0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule